// File: doc/BRIEF.md
# Dot-Clock Panel Timing Generator

This block produces the scan timing for an RGB panel driven by a pixel clock: horizontal sync, vertical sync, a data-enable strobe and a pixel request strobe that tells an upstream pixel source when to deliver the next pixel. The whole geometry is programmed through a simple write port as whole-line and whole-frame totals, sync pulse widths, back-porch wait counts measured from the start of the line or frame, an active width, and active line and pixel transfer counts. The block keeps no separate front-porch values; the front porch is whatever remains of the totals.

Every output polarity can be chosen on its own. A separate bit is passed out to the clock logic to say whether data is launched on the falling pixel-clock edge. The block also holds a current and a next frame-buffer base address. Software may write the next address at any time, and it becomes current only at the start of the next frame. The block reports the horizontal and vertical position of the scan and a one-cycle frame-start pulse.

A small state machine controls the scan. ST_IDLE holds the counters at zero and moves to ST_SCAN when run and sync-enable are both set. ST_SCAN moves to ST_DRAIN when run is cleared before the frame ends, or straight to ST_IDLE when run is cleared on the last cycle of a frame. ST_DRAIN finishes the frame and then goes to ST_SCAN if run and sync-enable are set again, or to ST_IDLE otherwise. All scan outputs pass through one register stage, so they stay aligned with each other and with the reported position.

Top module: `dotclk_timing_gen`

## Requirements
- R1: After reset, running_o, frame_start_o and pix_req_o are 0, cur_base_o is 0, and hsync_o, vsync_o and de_o are 1 (their inactive level under the reset polarity, active low).
- R2: The control register is at write address 0. Bit 0 is run and bit 1 is sync-enable. Scanning starts only when both bits are 1. Run set without sync-enable leaves running_o at 0 and produces no frame-start pulse.
- R3: Address 1 holds the line total HT in clocks and address 3 holds the hsync width in clocks. h_pos_o counts 0 to HT-1 and then wraps, and hsync is active while h_pos_o < hsync width.
- R4: Address 2 holds the frame total VT in lines and address 4 holds the vsync width. v_pos_o counts 0 to VT-1, stepping at each line wrap. When control bit 6 is 1, vsync is active while v_pos_o < width. When bit 6 is 0, vsync is active for the first width clocks of the frame.
- R5: Address 5 holds the horizontal wait, address 6 the vertical wait and address 7 the valid pixel count. Address 8 holds the pixel transfer count in bits 15:0 and the line transfer count in bits 31:16. Data-enable is active when hwait <= h < hwait+valid and vwait <= v < vwait+line count.
- R6: pix_req_o (always active high) is 1 when data-enable is active and h-hwait is less than the pixel transfer count.
- R7: Control bits 2, 3 and 4 make hsync, vsync and data-enable active high when 1 and active low when 0.
- R8: frame_start_o pulses for exactly one cycle, in the cycle where the reported position is (0,0) during a scan.
- R9: A write to address 9 sets the next base. cur_base_o takes that value in the cycle frame_start_o is 1 and stays unchanged at all other times, whatever writes are made mid-frame.
- R10: Clearing run mid-frame lets that frame complete unchanged. After it, running_o is 0, no further frame starts, and the sync and data-enable outputs sit at their inactive levels.
- R11: launch_fall_o follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW (32) | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 2 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| de_o | output | 1 | Data enable, polarity per control bit 4 |
| pix_req_o | output | 1 | Pixel request strobe |
| frame_start_o | output | 1 | One-cycle frame-start pulse |
| running_o | output | 1 | Scan in progress |
| h_pos_o | output | HW (18) | Horizontal position |
| v_pos_o | output | VW (16) | Vertical position |
| cur_base_o | output | AW (32) | Current frame-buffer base |
| launch_fall_o | output | 1 | Falling-edge data-launch select |

## Verification
The assertions check, on every cycle, the rules of the state machine: it cannot leave ST_IDLE without both enables, and it holds ST_DRAIN until the frame ends. They also check that the horizontal position stays inside the line, that the current base moves only on a frame start, that the frame-start pulse never lasts two cycles, and that an idle block requests no pixels. Only the bench scenarios can show the full sync, data-enable and request waveform against an independently computed frame. The same holds for the two vsync units, the polarity settings, the shadowed base swap seen across two frames, and the clean finish of the frame after run is cleared.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_HTOT   = 4'd1;
    localparam logic [ADDR_W-1:0] A_VTOT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_HSW    = 4'd3;
    localparam logic [ADDR_W-1:0] A_VSW    = 4'd4;
    localparam logic [ADDR_W-1:0] A_HWAIT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VWAIT  = 4'd6;
    localparam logic [ADDR_W-1:0] A_HVALID = 4'd7;
    localparam logic [ADDR_W-1:0] A_XFER   = 4'd8;
    localparam logic [ADDR_W-1:0] A_NEXT   = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    // control word, bit 6 down to bit 0
    typedef struct packed {
        logic vs_unit_lines;
        logic launch_fall;
        logic de_hi;
        logic vs_hi;
        logic hs_hi;
        logic sync_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 32,
    parameter int HW      = 18,
    parameter int VW      = 16,
    parameter int HWAIT_W = 12,
    parameter int XW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               swap,
    output ctrl_t              ctrl,
    output logic [HW-1:0]      htotal,
    output logic [VW-1:0]      vtotal,
    output logic [HW-1:0]      hs_width,
    output logic [HW-1:0]      vs_width,
    output logic [HWAIT_W-1:0] hwait,
    output logic [VW-1:0]      vwait,
    output logic [HW-1:0]      hvalid,
    output logic [XW-1:0]      hcount,
    output logic [XW-1:0]      vcount,
    output logic [AW-1:0]      cur_base
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [AW-1:0] next_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            htotal    <= '0;
            vtotal    <= '0;
            hs_width  <= '0;
            vs_width  <= '0;
            hwait     <= '0;
            vwait     <= '0;
            hvalid    <= '0;
            hcount    <= '0;
            vcount    <= '0;
            next_base <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:   ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_HTOT:   htotal    <= wr_data[HW-1:0];
                A_VTOT:   vtotal    <= wr_data[VW-1:0];
                A_HSW:    hs_width  <= wr_data[HW-1:0];
                A_VSW:    vs_width  <= wr_data[HW-1:0];
                A_HWAIT:  hwait     <= wr_data[HWAIT_W-1:0];
                A_VWAIT:  vwait     <= wr_data[VW-1:0];
                A_HVALID: hvalid    <= wr_data[HW-1:0];
                A_XFER: begin
                    hcount <= wr_data[XW-1:0];
                    vcount <= wr_data[2*XW-1:XW];
                end
                A_NEXT:   next_base <= wr_data[AW-1:0];
                default: ;
            endcase
        end
    end

    // shadow copy: current base only moves at a frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cur_base <= '0;
        else if (swap) cur_base <= next_base;
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(cur_base)); // R9
endmodule

// File: rtl/dtg_run_fsm.sv
module dtg_run_fsm
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sync_en,
    input  logic frame_end,
    output logic busy
);
    run_state_t state, nxt;
    logic       go;

    assign go = run && sync_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = ST_SCAN;
            ST_SCAN:  if (!run) nxt = frame_end ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (frame_end) nxt = go ? ST_SCAN : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_SCAN, ST_DRAIN: busy = 1'b1;
            default:           busy = 1'b0;
        endcase
    end

    AST_START_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !go) |=> state == ST_IDLE); // R2
    AST_DRAIN_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !frame_end) |=> state == ST_DRAIN); // R10
endmodule

// File: rtl/dtg_scan_counters.sv
module dtg_scan_counters #(
    parameter int HW = 18,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [HW-1:0] htotal,
    input  logic [VW-1:0] vtotal,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic [HW-1:0] vclk,
    output logic          frame_end,
    output logic          frame_start
);
    logic line_end;

    assign line_end    = ({1'b0, h} + (HW+1)'(1)) >= {1'b0, htotal};
    assign frame_end   = busy && line_end && (({1'b0, v} + (VW+1)'(1)) >= {1'b0, vtotal});
    assign frame_start = busy && (h == '0) && (v == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h <= '0;
            v <= '0;
        end else if (!busy) begin
            h <= '0;
            v <= '0;
        end else if (line_end) begin
            h <= '0;
            v <= frame_end ? '0 : v + VW'(1);
        end else begin
            h <= h + HW'(1);
        end
    end

    // clocks since frame start, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   vclk <= '0;
        else if (!busy || frame_end)  vclk <= '0;
        else if (vclk != '1)          vclk <= vclk + HW'(1);
    end

    AST_H_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && htotal != '0 && $stable(htotal)) |-> h < htotal); // R3
endmodule

// File: rtl/dotclk_timing_gen.sv
module dotclk_timing_gen
    import dtg_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 32,
    parameter int HW      = 18,
    parameter int VW      = 16,
    parameter int HWAIT_W = 12,
    parameter int XW      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              pix_req_o,
    output logic              frame_start_o,
    output logic              running_o,
    output logic [HW-1:0]     h_pos_o,
    output logic [VW-1:0]     v_pos_o,
    output logic [AW-1:0]     cur_base_o,
    output logic              launch_fall_o
);
    localparam int CMP_W = 32;

    ctrl_t              ctrl;
    logic [HW-1:0]      htotal, hs_width, vs_width, hvalid, h, vclk;
    logic [VW-1:0]      vtotal, vwait, v;
    logic [HWAIT_W-1:0] hwait;
    logic [XW-1:0]      hcount, vcount;
    logic               busy, frame_end, frame_start;

    dtg_cfg_regs #(.DW(DW), .AW(AW), .HW(HW), .VW(VW), .HWAIT_W(HWAIT_W), .XW(XW)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .swap(frame_start), .ctrl(ctrl), .htotal(htotal), .vtotal(vtotal),
        .hs_width(hs_width), .vs_width(vs_width), .hwait(hwait), .vwait(vwait),
        .hvalid(hvalid), .hcount(hcount), .vcount(vcount), .cur_base(cur_base_o)
    );

    dtg_run_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .sync_en(ctrl.sync_en),
        .frame_end(frame_end), .busy(busy)
    );

    dtg_scan_counters #(.HW(HW), .VW(VW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .htotal(htotal), .vtotal(vtotal),
        .h(h), .v(v), .vclk(vclk), .frame_end(frame_end), .frame_start(frame_start)
    );

    logic [CMP_W-1:0] hp, vp, cp, hwt, vwt;
    logic             hs_raw, vs_raw, de_raw, req_raw, h_win, v_win;

    always_comb begin
        hp  = CMP_W'(h);
        vp  = CMP_W'(v);
        cp  = CMP_W'(vclk);
        hwt = CMP_W'(hwait);
        vwt = CMP_W'(vwait);
        h_win   = (hp >= hwt) && (hp < hwt + CMP_W'(hvalid));
        v_win   = (vp >= vwt) && (vp < vwt + CMP_W'(vcount));
        hs_raw  = busy && ctrl.sync_en && (h < hs_width);
        vs_raw  = busy && ctrl.sync_en &&
                  (ctrl.vs_unit_lines ? (vp < CMP_W'(vs_width)) : (cp < CMP_W'(vs_width)));
        de_raw  = busy && h_win && v_win;
        req_raw = de_raw && ((hp - hwt) < CMP_W'(hcount));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_o       <= 1'b1;
            vsync_o       <= 1'b1;
            de_o          <= 1'b1;
            pix_req_o     <= 1'b0;
            frame_start_o <= 1'b0;
            running_o     <= 1'b0;
            h_pos_o       <= '0;
            v_pos_o       <= '0;
        end else begin
            hsync_o       <= hs_raw ^ ~ctrl.hs_hi;
            vsync_o       <= vs_raw ^ ~ctrl.vs_hi;
            de_o          <= de_raw ^ ~ctrl.de_hi;
            pix_req_o     <= req_raw;
            frame_start_o <= frame_start;
            running_o     <= busy;
            h_pos_o       <= h;
            v_pos_o       <= v;
        end
    end

    assign launch_fall_o = ctrl.launch_fall;

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && htotal > HW'(1)) |=> !frame_start_o); // R8
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!pix_req_o && !frame_start_o && !running_o)); // R10
endmodule

// File: tb/dotclk_timing_gen_tb_top.sv
module dotclk_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, running_o, launch_fall_o;
    logic [17:0] h_pos_o;
    logic [15:0] v_pos_o;
    logic [31:0] cur_base_o;

    always #4 clk = ~clk; // 125 MHz

    dotclk_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req_o(pix_req_o),
        .frame_start_o(frame_start_o), .running_o(running_o), .h_pos_o(h_pos_o),
        .v_pos_o(v_pos_o), .cur_base_o(cur_base_o), .launch_fall_o(launch_fall_o)
    );

    typedef struct packed {
        logic        run;
        logic        fs;
        logic        hs;
        logic        vs;
        logic        de;
        logic        req;
        logic [17:0] h;
        logic [15:0] v;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    armed  = 0;
    bit    synced = 0;
    int    cyc    = 0;

    int c_ht, c_vt, c_hsw, c_vsw, c_hwt, c_hvl, c_hcn, c_vwt, c_vcn;
    bit c_unit, c_hs_hi, c_vs_hi, c_de_hi;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_geometry();
        wr(4'd1, 32'(c_ht));
        wr(4'd2, 32'(c_vt));
        wr(4'd3, 32'(c_hsw));
        wr(4'd4, 32'(c_vsw));
        wr(4'd5, 32'(c_hwt));
        wr(4'd6, 32'(c_vwt));
        wr(4'd7, 32'(c_hvl));
        wr(4'd8, {16'(c_vcn), 16'(c_hcn)});
    endtask

    // driver: expected scan items computed from R3..R8
    task automatic push_frames(input int n);
        for (int f = 0; f < n; f++) begin
            for (int i = 0; i < c_ht * c_vt; i++) begin
                item_t e;
                int hh, vv;
                bit hs, vs, de, rq;
                hh = i % c_ht;
                vv = i / c_ht;
                hs = hh < c_hsw;
                vs = c_unit ? (vv < c_vsw) : (i < c_vsw);
                de = (hh >= c_hwt) && (hh < c_hwt + c_hvl) && (vv >= c_vwt) && (vv < c_vwt + c_vcn);
                rq = de && ((hh - c_hwt) < c_hcn);
                e.run = 1'b1;
                e.fs  = (i == 0);
                e.hs  = c_hs_hi ? hs : !hs;
                e.vs  = c_vs_hi ? vs : !vs;
                e.de  = c_de_hi ? de : !de;
                e.req = rq;
                e.h   = 18'(hh);
                e.v   = 16'(vv);
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) begin
            item_t e;
            e = '0;
            e.hs = !c_hs_hi;
            e.vs = !c_vs_hi;
            e.de = !c_de_hi;
            exp_q.push_back(e);
        end
    endtask

    // monitor: pops and compares once the first frame start is seen
    initial begin
        int idx;
        idx = 0;
        forever begin
            @(negedge clk);
            if (armed) begin
                if (!synced && frame_start_o) begin
                    synced = 1;
                    idx = 0;
                end
                if (synced) begin
                    item_t e, a;
                    e = exp_q.pop_front();
                    a = {running_o, frame_start_o, hsync_o, vsync_o, de_o, pix_req_o, h_pos_o, v_pos_o};
                    checks++;
                    if (a !== e) begin
                        fails++;
                        $display("FAIL R3 R4 R5 R6 R7 R8 R10 item %0d act=%h exp=%h", idx, a, e);
                    end
                    idx++;
                    if (exp_q.size() == 0) begin
                        synced = 0;
                        armed  = 0;
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                fails++;
                checks++;
                $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
                $display("[TB] %0d tests run, %0d failed", checks, fails);
                $finish;
            end
        end
    end

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start_o);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset levels
        check(hsync_o === 1'b1 && vsync_o === 1'b1 && de_o === 1'b1, "R1 sync/de idle", {hsync_o, vsync_o, de_o}, 3'b111);
        check(running_o === 1'b0 && frame_start_o === 1'b0 && pix_req_o === 1'b0, "R1 status", {running_o, frame_start_o, pix_req_o}, 0);
        check(cur_base_o === 32'd0, "R1 base", cur_base_o, 0);

        // ---- scenario A: active-low outputs, vsync in lines
        c_ht = 12; c_vt = 8; c_hsw = 2; c_vsw = 2; c_unit = 1;
        c_hwt = 4; c_hvl = 5; c_hcn = 3; c_vwt = 3; c_vcn = 3;
        c_hs_hi = 0; c_vs_hi = 0; c_de_hi = 0;
        load_geometry();

        // R2: run without sync-enable is ignored
        wr(4'd0, 32'h41);
        begin
            bit seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (running_o || frame_start_o) seen = 1;
            end
            check(!seen, "R2 run without sync-enable", seen, 0);
        end
        check(launch_fall_o === 1'b0, "R11 launch clear", launch_fall_o, 0);

        push_frames(2);
        push_idle(6);
        armed = 1;
        wr(4'd0, 32'h43);
        while (!synced) @(negedge clk);
        repeat (c_ht * c_vt + 30) @(negedge clk);
        wr(4'd0, 32'h42); // R10: stop mid second frame
        while (armed) @(negedge clk);
        check(running_o === 1'b0, "R10 stopped after frame A", running_o, 0);

        // ---- scenario B: active-high outputs, vsync in clocks, base swap
        c_ht = 10; c_vt = 6; c_hsw = 3; c_vsw = 15; c_unit = 0;
        c_hwt = 2; c_hvl = 6; c_hcn = 9; c_vwt = 1; c_vcn = 4;
        c_hs_hi = 1; c_vs_hi = 1; c_de_hi = 1;
        load_geometry();
        wr(4'd9, 32'h0000_1000);
        wr(4'd0, 32'h3C); // polarities and launch bit, not yet running
        check(launch_fall_o === 1'b1, "R11 launch set", launch_fall_o, 1);
        check(cur_base_o === 32'd0, "R9 no swap while idle", cur_base_o, 0);

        push_frames(2);
        push_idle(6);
        armed = 1;
        wr(4'd0, 32'h3F);
        wait_fs();
        check(cur_base_o === 32'h1000, "R9 base at first frame start", cur_base_o, 32'h1000);
        repeat (5) @(negedge clk);
        wr(4'd9, 32'h0000_2000);
        repeat (3) @(negedge clk);
        check(cur_base_o === 32'h1000, "R9 base held mid-frame", cur_base_o, 32'h1000);
        wait_fs();
        check(cur_base_o === 32'h2000, "R9 base at second frame start", cur_base_o, 32'h2000);
        repeat (20) @(negedge clk);
        wr(4'd0, 32'h3E); // R10 stop
        while (armed) @(negedge clk);
        repeat (12) @(negedge clk);
        check(running_o === 1'b0 && frame_start_o === 1'b0, "R10 idle after stop", {running_o, frame_start_o}, 0);
        check(hsync_o === 1'b0 && vsync_o === 1'b0 && de_o === 1'b0, "R10 R7 inactive high-polarity", {hsync_o, vsync_o, de_o}, 0);
        check(cur_base_o === 32'h2000, "R9 base kept after stop", cur_base_o, 32'h2000);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule